// File: doc/BRIEF.md
# Interrupt vector address generator

This block chooses which pending interrupt the processor services next and produces the word address of the handler entry for it. Twenty request lines, each with its own enable, compete under a fixed priority. A global enable, a blocking input from the vector-change protection logic and two section-protection inputs decide whether any request may be taken at all. When one is taken, the block emits a one-cycle strobe that carries the handler address, and a one-cycle acknowledge to the winning source.

The handler table can sit either at the bottom of program memory or at the bottom of a boot section whose size is set by a 2-bit size code. The reset entry moves independently of the table, under control of a boot-reset fuse input. In the first cycle after reset is released, the block issues the reset entry address on the same strobe, before any interrupt. The section protection looks at the current program counter and blocks interrupts while code runs in a section that is not allowed to reach the table.

Top module: `irq_vector_gen`

## Requirements
- R1: While `rst` is high, `vec_valid` is 0, `irq_ack` is all zeros and `vec_addr` is 0.
- R2: On the first clock edge with `rst` low, the block raises `vec_valid` for one cycle with `irq_ack` all zeros. `vec_addr` then carries the reset entry: 0 when `fuse_boot_rst_n` is 1, and the boot section base when it is 0. The vector-select input has no effect on this address.
- R3: The boot section base, in words, depends on `boot_size`: code 0 gives 0xC00, code 1 gives 0xE00, code 2 gives 0xF00 and code 3 gives 0xF80.
- R4: Request bit j (j = 0..19) owns table slot j+1. Its handler address is j+1 when `vec_sel_boot` is 0, and boot base + j+1 when `vec_sel_boot` is 1.
- R5: A request is eligible when its `irq_req` bit and its `irq_enable` bit are both 1. When several are eligible, the lowest bit index wins.
- R6: A request whose `irq_enable` bit is 0 is never acknowledged. It stays pending and is taken once its enable is set.
- R7: No interrupt is taken while `global_ie` is 0 or `block_irq` is 1.
- R8: When `vec_sel_boot` is 1 and `lock_app` is 1, no interrupt is taken while `pc` is below the boot base. At `pc` equal to the base, interrupts are taken.
- R9: When `vec_sel_boot` is 0 and `lock_boot` is 1, no interrupt is taken while `pc` is at or above the boot base. Below the base, interrupts are taken.
- R10: A take is registered on the clock edge that samples the eligible request. It shows as `vec_valid` high for one cycle together with a one-hot `irq_ack`. The cycle after any strobe never carries a strobe.
- R11: `vec_addr` changes only in a cycle in which `vec_valid` is high, and otherwise holds its last value.
- R12: If a request is eligible in the cycle of the reset-entry strobe, the reset entry is issued first. The request is taken on the first allowed cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Pending request lines, bit j for table slot j+1 |
| irq_enable | input | NUM_SRC | Per-source enable |
| global_ie | input | 1 | Global interrupt enable |
| block_irq | input | 1 | Temporary block from vector-change protection |
| vec_sel_boot | input | 1 | 1 places the handler table at the boot base |
| fuse_boot_rst_n | input | 1 | 0 moves the reset entry to the boot base |
| boot_size | input | 2 | Boot section size code |
| lock_app | input | 1 | Block interrupts in application code when table is in boot |
| lock_boot | input | 1 | Block interrupts in boot code when table is in application |
| pc | input | PC_W | Current program counter (word address) |
| vec_valid | output | 1 | One-cycle strobe, address valid |
| vec_addr | output | PC_W | Reset entry or handler address |
| irq_ack | output | NUM_SRC | One-cycle one-hot acknowledge to the winner |

## Verification
The reset-entry fetch and an interrupt take can fall due in the same cycle: the first cycle after reset release. The bench provokes this by holding an enabled request with the global enable set while reset is still asserted, and with the reset entry moved to the boot base. It then expects the reset address with no acknowledge, one empty cycle, and then the handler address with the acknowledge. A behavioural model computes every cycle's outputs from the sampled inputs and is compared on each clock.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [1:0] {
    BSZ_LARGE = 2'd0,
    BSZ_MID   = 2'd1,
    BSZ_SMALL = 2'd2,
    BSZ_MIN   = 2'd3
  } boot_size_e;
endpackage

// File: rtl/irqv_boot_map.sv
// Decodes the boot base from the size code and gates interrupts by section.
module irqv_boot_map #(
  parameter int unsigned PC_W    = 12,
  parameter int unsigned BASE_L  = 32'hC00,
  parameter int unsigned BASE_M  = 32'hE00,
  parameter int unsigned BASE_S  = 32'hF00,
  parameter int unsigned BASE_XS = 32'hF80
) (
  input  logic [1:0]      boot_size,
  input  logic [PC_W-1:0] pc,
  input  logic            vec_sel_boot,
  input  logic            lock_app,
  input  logic            lock_boot,
  output logic [PC_W-1:0] boot_base,
  output logic            gate_block
);
  import irqv_pkg::*;

  logic in_boot;

  always_comb begin
    case (boot_size_e'(boot_size))
      BSZ_LARGE: boot_base = PC_W'(BASE_L);
      BSZ_MID:   boot_base = PC_W'(BASE_M);
      BSZ_SMALL: boot_base = PC_W'(BASE_S);
      default:   boot_base = PC_W'(BASE_XS);
    endcase
  end

  assign in_boot    = (pc >= boot_base);
  assign gate_block = (vec_sel_boot & lock_app & ~in_boot) |
                      (~vec_sel_boot & lock_boot & in_boot);
endmodule

// File: rtl/irqv_prio.sv
// Fixed priority: the lowest eligible index wins.
module irqv_prio #(
  parameter int unsigned N     = 20,
  parameter int unsigned IDX_W = 5
) (
  input  logic [N-1:0]     elig,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = elig[i] & ~seen[i];
    assign seen[i+1] = seen[i] | elig[i];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int unsigned PC_W    = 12,
  parameter int unsigned NUM_SRC = 20,
  parameter int unsigned BASE_L  = 32'hC00,
  parameter int unsigned BASE_M  = 32'hE00,
  parameter int unsigned BASE_S  = 32'hF00,
  parameter int unsigned BASE_XS = 32'hF80
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_enable,
  input  logic               global_ie,
  input  logic               block_irq,
  input  logic               vec_sel_boot,
  input  logic               fuse_boot_rst_n,
  input  logic [1:0]         boot_size,
  input  logic               lock_app,
  input  logic               lock_boot,
  input  logic [PC_W-1:0]    pc,
  output logic               vec_valid,
  output logic [PC_W-1:0]    vec_addr,
  output logic [NUM_SRC-1:0] irq_ack
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC + 1);

  logic [PC_W-1:0]    boot_base;
  logic               gate_block;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] grant;
  logic [IDX_W-1:0]   win_idx;
  logic               win_any;
  logic               rst_pend;
  logic               take;
  logic [PC_W-1:0]    slot_addr;
  logic [PC_W-1:0]    vec_target;
  logic [PC_W-1:0]    rst_target;

  irqv_boot_map #(
    .PC_W(PC_W), .BASE_L(BASE_L), .BASE_M(BASE_M),
    .BASE_S(BASE_S), .BASE_XS(BASE_XS)
  ) map_i (
    .boot_size    (boot_size),
    .pc           (pc),
    .vec_sel_boot (vec_sel_boot),
    .lock_app     (lock_app),
    .lock_boot    (lock_boot),
    .boot_base    (boot_base),
    .gate_block   (gate_block)
  );

  assign elig = irq_req & irq_enable;

  irqv_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) prio_i (
    .elig  (elig),
    .grant (grant),
    .idx   (win_idx),
    .any   (win_any)
  );

  // One idle cycle after every strobe lets the acknowledged source drop.
  assign take = ~rst_pend & ~vec_valid & global_ie & ~block_irq &
                ~gate_block & win_any;

  assign slot_addr  = {{(PC_W-IDX_W){1'b0}}, win_idx} + PC_W'(1);
  assign vec_target = (vec_sel_boot ? boot_base : '0) + slot_addr;
  assign rst_target = fuse_boot_rst_n ? '0 : boot_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pend  <= 1'b1;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      irq_ack   <= '0;
    end else begin
      irq_ack <= take ? grant : '0;
      if (rst_pend) begin
        rst_pend  <= 1'b0;
        vec_valid <= 1'b1;
        vec_addr  <= rst_target;
      end else if (take) begin
        vec_valid <= 1'b1;
        vec_addr  <= vec_target;
      end else begin
        vec_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int unsigned PC_W    = 12,
  parameter int unsigned NUM_SRC = 20
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] irq_req,
  input logic [NUM_SRC-1:0] irq_enable,
  input logic               global_ie,
  input logic               block_irq,
  input logic               vec_valid,
  input logic [PC_W-1:0]    vec_addr,
  input logic [NUM_SRC-1:0] irq_ack
);
  assert_reset_entry_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> (vec_valid && irq_ack == '0))
    else $error("reset entry strobe missing");

  assert_ack_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_ack) && ((irq_ack != '0) -> vec_valid))
    else $error("acknowledge not one-hot or without strobe");

  assert_strobe_gap_R10: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid)
    else $error("back-to-back strobes");

  assert_ack_had_request_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_ack != '0) |-> ((irq_ack & $past(irq_req)) != '0))
    else $error("acknowledge without request");

  assert_ack_enabled_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_ack & ~$past(irq_enable)) == '0)
    else $error("disabled source acknowledged");

  assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_ack != '0) |-> $past(global_ie && !block_irq))
    else $error("take while globally blocked");

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !vec_valid |-> $stable(vec_addr))
    else $error("address moved without strobe");
endmodule

bind irq_vector_gen irqv_checker #(.PC_W(PC_W), .NUM_SRC(NUM_SRC)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .irq_req    (irq_req),
  .irq_enable (irq_enable),
  .global_ie  (global_ie),
  .block_irq  (block_irq),
  .vec_valid  (vec_valid),
  .vec_addr   (vec_addr),
  .irq_ack    (irq_ack)
);

// File: tb/irq_vector_gen_tb_top.sv
module irq_vector_gen_tb_top;
  localparam int unsigned PC_W = 12;
  localparam int unsigned NS   = 20;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS-1:0]   irq_req = '0;
  logic [NS-1:0]   irq_enable = '0;
  logic            global_ie = 1'b0;
  logic            block_irq = 1'b0;
  logic            vec_sel_boot = 1'b0;
  logic            fuse_boot_rst_n = 1'b1;
  logic [1:0]      boot_size = 2'd0;
  logic            lock_app = 1'b0;
  logic            lock_boot = 1'b0;
  logic [PC_W-1:0] pc = '0;
  logic            vec_valid;
  logic [PC_W-1:0] vec_addr;
  logic [NS-1:0]   irq_ack;

  always #4 clk = ~clk;

  irq_vector_gen dut_i (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_enable(irq_enable),
    .global_ie(global_ie), .block_irq(block_irq), .vec_sel_boot(vec_sel_boot),
    .fuse_boot_rst_n(fuse_boot_rst_n), .boot_size(boot_size),
    .lock_app(lock_app), .lock_boot(lock_boot), .pc(pc),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .irq_ack(irq_ack)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Boot base per size code (R3)
  function automatic int base_of(input logic [1:0] sz);
    case (sz)
      2'd0: return 'hC00;
      2'd1: return 'hE00;
      2'd2: return 'hF00;
      default: return 'hF80;
    endcase
  endfunction

  // Behavioural reference model
  bit          e_valid = 0;
  int          e_addr = 0;
  int          e_ack = 0;
  bit          e_rstp = 1;

  always @(posedge clk) begin
    int  b;
    int  win;
    bit  blk;
    b = base_of(boot_size);
    if (rst) begin
      e_valid = 0; e_addr = 0; e_ack = 0; e_rstp = 1;
    end else if (e_rstp) begin
      e_valid = 1; e_ack = 0; e_rstp = 0;
      e_addr = fuse_boot_rst_n ? 0 : b;
    end else begin
      win = -1;
      for (int j = NS - 1; j >= 0; j--)
        if (irq_req[j] && irq_enable[j]) win = j;
      blk = (vec_sel_boot && lock_app && int'(pc) < b) ||
            (!vec_sel_boot && lock_boot && int'(pc) >= b);
      if (!e_valid && global_ie && !block_irq && !blk && win >= 0) begin
        e_valid = 1;
        e_ack = 1 << win;
        e_addr = (vec_sel_boot ? b : 0) + win + 1;
      end else begin
        e_valid = 0; e_ack = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  // Per-cycle comparison; sources drop a request once acknowledged
  always @(negedge clk) begin
    if (!done) begin
      chk(vec_valid === e_valid, {cur_req, " valid"}, int'(vec_valid), int'(e_valid));
      chk(vec_addr === PC_W'(e_addr), {cur_req, " addr"}, int'(vec_addr), e_addr);
      chk(irq_ack === NS'(e_ack), {cur_req, " ack"}, int'(irq_ack), e_ack);
      irq_req = irq_req & ~irq_ack;
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_take(input int a, input int k, input string r);
    bit seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      @(negedge clk);
      #1;
      if (vec_valid) begin
        seen = 1;
        chk(vec_addr === PC_W'(a), {r, " strobe addr"}, int'(vec_addr), a);
        chk(irq_ack === NS'(k), {r, " strobe ack"}, int'(irq_ack), k);
        @(negedge clk);
        #1;
        chk(!vec_valid, "R10 gap after strobe", int'(vec_valid), 0);
      end
    end
    if (!seen) chk(1'b0, {r, " no strobe"}, 0, 1);
  endtask

  task automatic expect_none(input int n, input string r);
    int cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      if (vec_valid) cnt++;
    end
    chk(cnt == 0, {r, " unexpected strobe"}, cnt, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) step();
    @(negedge clk); #1;
    chk(!vec_valid && vec_addr == '0 && irq_ack == '0, "R1 reset state",
        int'(vec_addr), 0);

    // R12 / R2: reset entry at boot base collides with pending request
    step();
    cur_req = "R12";
    fuse_boot_rst_n = 1'b0;
    irq_enable = '1;
    global_ie = 1'b1;
    irq_req = NS'(1) << 3;
    step();
    rst = 1'b0;
    expect_take('hC00, 0, "R12 reset first");
    expect_take(4, 1 << 3, "R12 request after");

    // R2: reset entry at zero with fuse unprogrammed, vector select ignored
    step();
    cur_req = "R2";
    rst = 1'b1;
    fuse_boot_rst_n = 1'b1;
    vec_sel_boot = 1'b1;
    repeat (2) step();
    rst = 1'b0;
    expect_take(0, 0, "R2 reset entry");
    step();
    vec_sel_boot = 1'b0;

    // R5: priority among three
    cur_req = "R5";
    irq_req = (NS'(1) << 0) | (NS'(1) << 5) | (NS'(1) << 19);
    expect_take(1, 1 << 0, "R5 first");
    expect_take(6, 1 << 5, "R5 second");
    expect_take(20, 1 << 19, "R5 third");

    // R6: disabled source stays pending
    step();
    cur_req = "R6";
    irq_enable = ~(NS'(1) << 2);
    irq_req = (NS'(1) << 2) | (NS'(1) << 7);
    expect_take(8, 1 << 7, "R6 enabled one");
    expect_none(6, "R6 disabled");
    step();
    irq_enable = '1;
    expect_take(3, 1 << 2, "R6 enabled later");

    // R7: global enable and block input
    step();
    cur_req = "R7";
    global_ie = 1'b0;
    irq_req = NS'(1) << 1;
    expect_none(5, "R7 global off");
    step();
    global_ie = 1'b1;
    block_irq = 1'b1;
    expect_none(5, "R7 blocked");
    step();
    block_irq = 1'b0;
    expect_take(2, 1 << 1, "R7 released");

    // R3 / R4: table in boot section for every size code
    vec_sel_boot = 1'b1;
    for (int sz = 0; sz < 4; sz++) begin
      step();
      cur_req = "R3";
      boot_size = 2'(sz);
      irq_req = (NS'(1) << 0) | (NS'(1) << 19);
      expect_take(base_of(2'(sz)) + 1, 1 << 0, "R4 boot slot 1");
      expect_take(base_of(2'(sz)) + 20, 1 << 19, "R3 boot slot 20");
    end

    // R8: application-side block with table in boot
    step();
    cur_req = "R8";
    boot_size = 2'd0;
    lock_app = 1'b1;
    pc = 12'hBFF;
    irq_req = NS'(1) << 4;
    expect_none(5, "R8 pc below base");
    step();
    pc = 12'hC00;
    expect_take('hC05, 1 << 4, "R8 pc at base");
    step();
    lock_app = 1'b0;

    // R9: boot-side block with table in application
    cur_req = "R9";
    vec_sel_boot = 1'b0;
    lock_boot = 1'b1;
    pc = 12'hC00;
    irq_req = NS'(1) << 9;
    expect_none(5, "R9 pc at base");
    step();
    pc = 12'hBFF;
    expect_take(10, 1 << 9, "R9 pc below base");

    // R11: address holds while idle
    step();
    cur_req = "R11";
    expect_none(4, "R11 idle");
    chk(vec_addr == PC_W'(10), "R11 hold", int'(vec_addr), 10);

    repeat (2) step();
    finish_run();
  end
endmodule